// File: doc/BRIEF.md
# Binary Decision Decoder Engine

This block resolves one context-coded binary decision from an adaptive binary arithmetic coded stream for each request it accepts. The caller supplies the selected context's 6-bit probability state and its most-probable-symbol (MPS) bit, together with the current 9-bit interval width (range) and the 9-bit code offset. The engine looks up the width of the least-probable-symbol (LPS) sub-interval from a table indexed by state and range quarter. It compares the offset against the remaining MPS sub-interval and returns three things: the decoded bin, the adapted state and MPS bit for the caller to write back, and the new range and offset. The range and offset are returned before renormalisation.

The state-transition rules and the LPS width table are held inside the block and computed when it is elaborated. A separate initialisation request starts a slice. It loads the full starting range and takes the offset from the caller's first stream bits, because no history carries over from one slice to the next. Context selection, renormalisation, bit fetching, equiprobable decoding and syntax parsing are left to neighbouring logic. Requests and results move over valid/ready handshakes. The result of each accepted request is registered and appears one cycle after acceptance.

Top module: `bin_decoder_engine`

## Requirements
- R1: After reset, `res_valid` is 0 and `req_ready` is 1.
- R2: The LPS width is max(2, (P(s) * C(q)) >> 16). Here q is range bits [7:6], C(q) = 288 + 64*q, P(0) = 32768 and P(s+1) = (P(s) * 62206) >> 16, all in integer arithmetic.
- R3: Let the MPS width be range minus the LPS width. When the offset is equal to or greater than the MPS width, the bin is the inverse of the MPS bit, the offset loses the MPS width, and the range becomes the LPS width.
- R4: When the offset is below the MPS width, the bin equals the MPS bit, the offset is unchanged, and the range becomes the MPS width.
- R5: After an MPS decision the state becomes s+1 for s < 62. State 62 stays at 62 and state 63 stays at 63.
- R6: After an LPS decision the state becomes 0 for s = 0, stays 63 for s = 63, and becomes s - 1 - (s >> 3) otherwise.
- R7: An LPS decision in state 0 inverts the returned MPS bit. Every other decision returns the MPS bit unchanged.
- R8: An initialisation request (`req_init` = 1) returns range 510 and the request's offset. It passes state and MPS through unchanged and returns bin 0.
- R9: A request is accepted when `req_valid` and `req_ready` are both 1. Its result is presented with `res_valid` = 1 in the following cycle. The result stays stable while `res_ready` is 0, and `req_ready` equals (not `res_valid`) or `res_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can take a request |
| req_init | input | 1 | 1 = slice-start initialisation, 0 = decision |
| req_state | input | 6 | Probability state of the selected context |
| req_mps | input | 1 | MPS bit of the selected context |
| req_range | input | 9 | Current range (normalised, 256..510) |
| req_offset | input | 9 | Current offset (below range), or the initial offset |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_bin | output | 1 | Decoded bin |
| res_state | output | 6 | Adapted state for write-back |
| res_mps | output | 1 | Adapted MPS bit for write-back |
| res_range | output | 9 | New range before renormalisation |
| res_offset | output | 9 | New offset before renormalisation |

## Verification
The bench targets the equality point where the offset equals the MPS width. A design that used a strict greater-than there would return the MPS with an oversized range. It also targets an LPS in state 0: a design that never inverted the MPS bit, or inverted it in every state, would leave a context stuck or make it flip about. The top states are checked as well. A design that saturated at 63 instead of 62, or let state 63 adapt, would show up there. Each range quarter is exercised at one state to catch a wrong quarter slice. Finally, a stalled consumer is held against a waiting request, to show that a result neither changes nor gets lost under back-pressure.

// File: rtl/bin_dec_pkg.sv
package bin_dec_pkg;

    localparam int unsigned PROB_START = 32768;   // 0.5 in Q16
    localparam int unsigned PROB_DECAY = 62206;   // per-state decay in Q16
    localparam int unsigned QTR_BASE   = 288;     // centre of the lowest quarter
    localparam int unsigned QTR_STEP   = 64;
    localparam int unsigned LPS_FLOOR  = 2;

    // LPS probability of a state, Q16
    function automatic longint unsigned lps_prob(input int unsigned s);
        longint unsigned p;
        p = longint'(PROB_START);
        for (int unsigned i = 0; i < s; i++) begin
            p = (p * longint'(PROB_DECAY)) >> 16;
        end
        return p;
    endfunction

    // LPS sub-interval width for a state and a range quarter
    function automatic int unsigned lps_width(input int unsigned s, input int unsigned q);
        longint unsigned w;
        w = (lps_prob(s) * longint'(QTR_BASE + QTR_STEP * q)) >> 16;
        if (w < longint'(LPS_FLOOR)) begin
            w = longint'(LPS_FLOOR);
        end
        return int'(w);
    endfunction

endpackage

// File: rtl/bin_lps_table.sv
module bin_lps_table #(
    parameter int STATE_W = 6,
    parameter int RANGE_W = 9
) (
    input  logic [STATE_W-1:0] state,
    input  logic [1:0]         quarter,
    output logic [RANGE_W-1:0] lps_w
);
    localparam int NUM_STATES = 1 << STATE_W;
    localparam int NUM_QTR    = 4;

    logic [RANGE_W-1:0] tbl [NUM_STATES][NUM_QTR];

    for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
        for (genvar q = 0; q < NUM_QTR; q++) begin : g_qtr
            localparam int unsigned ENTRY = bin_dec_pkg::lps_width(s, q);
            assign tbl[s][q] = RANGE_W'(ENTRY);
        end
    end

    assign lps_w = tbl[state][quarter];

endmodule

// File: rtl/bin_state_step.sv
module bin_state_step #(
    parameter int STATE_W = 6
) (
    input  logic [STATE_W-1:0] state,
    output logic [STATE_W-1:0] next_on_mps,
    output logic [STATE_W-1:0] next_on_lps
);
    localparam int NUM_STATES = 1 << STATE_W;
    localparam logic [STATE_W-1:0] FROZEN   = STATE_W'(NUM_STATES - 1);
    localparam logic [STATE_W-1:0] TOP_ADPT = STATE_W'(NUM_STATES - 2);

    logic is_frozen;
    assign is_frozen = (state == FROZEN);

    always_comb begin
        if (is_frozen || state == TOP_ADPT) begin
            next_on_mps = state;
        end else begin
            next_on_mps = state + STATE_W'(1);
        end

        if (is_frozen) begin
            next_on_lps = state;
        end else if (state == '0) begin
            next_on_lps = '0;
        end else begin
            next_on_lps = state - STATE_W'(1) - (state >> 3);
        end
    end

endmodule

// File: rtl/bin_decide.sv
module bin_decide #(
    parameter int STATE_W = 6,
    parameter int RANGE_W = 9
) (
    input  logic [STATE_W-1:0] state,
    input  logic               mps,
    input  logic [RANGE_W-1:0] range_in,
    input  logic [RANGE_W-1:0] offset_in,
    output logic               bin,
    output logic [STATE_W-1:0] state_out,
    output logic               mps_out,
    output logic [RANGE_W-1:0] range_out,
    output logic [RANGE_W-1:0] offset_out
);
    localparam int QTR_HI = RANGE_W - 2;
    localparam int QTR_LO = RANGE_W - 3;

    logic [RANGE_W-1:0] lps_w;
    logic [RANGE_W-1:0] mps_w;
    logic [STATE_W-1:0] nxt_mps;
    logic [STATE_W-1:0] nxt_lps;
    logic               take_lps;

    bin_lps_table #(.STATE_W(STATE_W), .RANGE_W(RANGE_W)) i_lps_table (
        .state   (state),
        .quarter (range_in[QTR_HI:QTR_LO]),
        .lps_w   (lps_w)
    );

    bin_state_step #(.STATE_W(STATE_W)) i_state_step (
        .state       (state),
        .next_on_mps (nxt_mps),
        .next_on_lps (nxt_lps)
    );

    assign mps_w    = range_in - lps_w;
    assign take_lps = (offset_in >= mps_w);

    always_comb begin
        if (take_lps) begin
            bin        = ~mps;
            range_out  = lps_w;
            offset_out = offset_in - mps_w;
            state_out  = nxt_lps;
            mps_out    = (state == '0) ? ~mps : mps;
        end else begin
            bin        = mps;
            range_out  = mps_w;
            offset_out = offset_in;
            state_out  = nxt_mps;
            mps_out    = mps;
        end
    end

endmodule

// File: rtl/bin_decoder_engine.sv
module bin_decoder_engine #(
    parameter int STATE_W    = 6,
    parameter int RANGE_W    = 9,
    parameter int INIT_RANGE = 510
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_init,
    input  logic [STATE_W-1:0] req_state,
    input  logic               req_mps,
    input  logic [RANGE_W-1:0] req_range,
    input  logic [RANGE_W-1:0] req_offset,
    output logic               res_valid,
    input  logic               res_ready,
    output logic               res_bin,
    output logic [STATE_W-1:0] res_state,
    output logic               res_mps,
    output logic [RANGE_W-1:0] res_range,
    output logic [RANGE_W-1:0] res_offset
);
    localparam logic [RANGE_W-1:0] START_RANGE = RANGE_W'(INIT_RANGE);

    typedef struct packed {
        logic               valid;
        logic               bin;
        logic [STATE_W-1:0] state;
        logic               mps;
        logic [RANGE_W-1:0] range;
        logic [RANGE_W-1:0] offset;
    } result_t;

    result_t res_d, res_q;

    logic               dec_bin;
    logic [STATE_W-1:0] dec_state;
    logic               dec_mps;
    logic [RANGE_W-1:0] dec_range;
    logic [RANGE_W-1:0] dec_offset;
    logic               accept;

    bin_decide #(.STATE_W(STATE_W), .RANGE_W(RANGE_W)) i_decide (
        .state      (req_state),
        .mps        (req_mps),
        .range_in   (req_range),
        .offset_in  (req_offset),
        .bin        (dec_bin),
        .state_out  (dec_state),
        .mps_out    (dec_mps),
        .range_out  (dec_range),
        .offset_out (dec_offset)
    );

    assign req_ready = ~res_q.valid | res_ready;
    assign accept    = req_valid & req_ready;

    always_comb begin
        res_d = res_q;
        if (res_ready) begin
            res_d.valid = 1'b0;
        end
        if (accept) begin
            res_d.valid = 1'b1;
            if (req_init) begin
                res_d.bin    = 1'b0;
                res_d.state  = req_state;
                res_d.mps    = req_mps;
                res_d.range  = START_RANGE;
                res_d.offset = req_offset;
            end else begin
                res_d.bin    = dec_bin;
                res_d.state  = dec_state;
                res_d.mps    = dec_mps;
                res_d.range  = dec_range;
                res_d.offset = dec_offset;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid  = res_q.valid;
    assign res_bin    = res_q.bin;
    assign res_state  = res_q.state;
    assign res_mps    = res_q.mps;
    assign res_range  = res_q.range;
    assign res_offset = res_q.offset;

endmodule

// File: rtl/bin_engine_checker.sv
module bin_engine_checker #(
    parameter int STATE_W    = 6,
    parameter int RANGE_W    = 9,
    parameter int INIT_RANGE = 510
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_init,
    input logic [STATE_W-1:0] req_state,
    input logic               req_mps,
    input logic [RANGE_W-1:0] req_range,
    input logic [RANGE_W-1:0] req_offset,
    input logic               res_valid,
    input logic               res_ready,
    input logic               res_bin,
    input logic [STATE_W-1:0] res_state,
    input logic               res_mps,
    input logic [RANGE_W-1:0] res_range,
    input logic [RANGE_W-1:0] res_offset
);
    localparam logic [STATE_W-1:0] LAST_STATE = STATE_W'((1 << STATE_W) - 1);

    logic               cap_init;
    logic [STATE_W-1:0] cap_state;
    logic               cap_mps;
    logic [RANGE_W-1:0] cap_range;
    logic [RANGE_W-1:0] cap_offset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_init   <= 1'b0;
            cap_state  <= '0;
            cap_mps    <= 1'b0;
            cap_range  <= '0;
            cap_offset <= '0;
        end else if (req_valid && req_ready) begin
            cap_init   <= req_init;
            cap_state  <= req_state;
            cap_mps    <= req_mps;
            cap_range  <= req_range;
            cap_offset <= req_offset;
        end
    end

    AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> res_valid); // R9
    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_bin) && $stable(res_range) && $stable(res_offset)); // R9
    AST_BLOCK_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |-> !req_ready); // R9
    AST_INIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && cap_init |-> res_range == RANGE_W'(INIT_RANGE) && res_offset == cap_offset); // R8
    AST_RANGE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !cap_init |-> res_range < cap_range && res_range != '0); // R3
    AST_OFFSET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !cap_init && cap_offset < cap_range |-> res_offset < res_range); // R4
    AST_MPS_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !cap_init && res_bin == cap_mps |-> res_offset == cap_offset); // R4
    AST_MPS_SENSE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !cap_init && cap_state != '0 |-> res_mps == cap_mps); // R7
    AST_FROZEN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !cap_init && cap_state == LAST_STATE |-> res_state == LAST_STATE); // R5

endmodule

bind bin_decoder_engine bin_engine_checker #(
    .STATE_W(STATE_W), .RANGE_W(RANGE_W), .INIT_RANGE(INIT_RANGE)
) i_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_init(req_init), .req_state(req_state), .req_mps(req_mps),
    .req_range(req_range), .req_offset(req_offset), .res_valid(res_valid),
    .res_ready(res_ready), .res_bin(res_bin), .res_state(res_state),
    .res_mps(res_mps), .res_range(res_range), .res_offset(res_offset)
);

// File: tb/test_bin_decoder_engine.sv
`timescale 1ns/1ps
module test_bin_decoder_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_init = 1'b0;
    logic [5:0] req_state = '0;
    logic       req_mps = 1'b0;
    logic [8:0] req_range = 9'd256;
    logic [8:0] req_offset = '0;
    logic       res_valid;
    logic       res_ready = 1'b1;
    logic       res_bin;
    logic [5:0] res_state;
    logic       res_mps;
    logic [8:0] res_range;
    logic [8:0] res_offset;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    bin_decoder_engine i_bin_decoder_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_init(req_init), .req_state(req_state), .req_mps(req_mps),
        .req_range(req_range), .req_offset(req_offset), .res_valid(res_valid),
        .res_ready(res_ready), .res_bin(res_bin), .res_state(res_state),
        .res_mps(res_mps), .res_range(res_range), .res_offset(res_offset)
    );

    // ---- reference model from the requirements ----
    function automatic int ref_prob(int s);
        longint p = 32768;
        for (int i = 0; i < s; i++) p = (p * 62206) >> 16;
        return int'(p);
    endfunction

    function automatic int ref_lps(int s, int rng);
        longint w;
        int q = (rng >> 6) & 3;
        w = (longint'(ref_prob(s)) * (288 + 64 * q)) >> 16;
        if (w < 2) w = 2;
        return int'(w);
    endfunction

    function automatic int ref_next_mps(int s);
        if (s >= 62) return s;
        return s + 1;
    endfunction

    function automatic int ref_next_lps(int s);
        if (s == 0) return 0;
        if (s == 63) return 63;
        return s - 1 - (s >> 3);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic issue(bit init, int st, bit mps, int rng, int off);
        @(negedge clk);
        req_valid  = 1'b1;
        req_init   = init;
        req_state  = 6'(st);
        req_mps    = mps;
        req_range  = 9'(rng);
        req_offset = 9'(off);
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    // one decision checked against the model; tag names the requirement under test
    task automatic decide(string req, int st, bit mps, int rng, int off);
        int lw = ref_lps(st, rng);
        int mw = rng - lw;
        bit lps = (off >= mw);
        issue(1'b0, st, mps, rng, off);
        check(req, "valid", int'(res_valid), 1);
        check(req, "bin", int'(res_bin), lps ? int'(!mps) : int'(mps));
        check(req, "range", int'(res_range), lps ? lw : mw);
        check(req, "offset", int'(res_offset), lps ? off - mw : off);
        check(req, "state", int'(res_state), lps ? ref_next_lps(st) : ref_next_mps(st));
        check(req, "mps", int'(res_mps), (lps && st == 0) ? int'(!mps) : int'(mps));
    endtask

    task automatic t_reset();
        check("R1", "res_valid after reset", int'(res_valid), 0);
        check("R1", "req_ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_init();
        issue(1'b1, 20, 1'b1, 300, 419);
        check("R8", "range", int'(res_range), 510);
        check("R8", "offset", int'(res_offset), 419);
        check("R8", "state", int'(res_state), 20);
        check("R8", "mps", int'(res_mps), 1);
        check("R8", "bin", int'(res_bin), 0);
    endtask

    task automatic t_table_anchor();
        // R2 anchor: state 0, lowest quarter gives 144, so MPS width 112 at range 256
        issue(1'b0, 0, 1'b1, 256, 0);
        check("R2", "state0 q0 MPS range", int'(res_range), 112);
        issue(1'b0, 0, 1'b1, 448, 0);
        check("R2", "state0 q3 MPS range", int'(res_range), 448 - 240);
    endtask

    task automatic t_quarters();
        for (int q = 0; q < 4; q++) decide("R2", 5, 1'b0, 256 + 64 * q, 0);
        decide("R2", 40, 1'b1, 510, 3);
    endtask

    task automatic t_mps_lps();
        decide("R4", 10, 1'b1, 300, 20);
        decide("R3", 10, 1'b0, 300, 299);
        decide("R6", 33, 1'b1, 400, 399);
        decide("R5", 33, 1'b0, 400, 10);
    endtask

    task automatic t_state_zero();
        issue(1'b0, 0, 1'b1, 256, 200);
        check("R7", "bin", int'(res_bin), 0);
        check("R7", "mps flipped", int'(res_mps), 0);
        check("R7", "offset", int'(res_offset), 88);
        check("R7", "range", int'(res_range), 144);
        check("R6", "state", int'(res_state), 0);
        decide("R7", 1, 1'b1, 256, 255);
    endtask

    task automatic t_equality();
        decide("R3", 0, 1'b0, 256, 112);
        check("R3", "equality gives LPS bin", int'(res_bin), 1);
        decide("R4", 0, 1'b0, 256, 111);
        check("R4", "one below gives MPS range", int'(res_range), 112);
    endtask

    task automatic t_saturation();
        decide("R5", 62, 1'b1, 300, 0);
        check("R5", "62 holds", int'(res_state), 62);
        decide("R5", 63, 1'b0, 300, 0);
        check("R5", "63 holds on MPS", int'(res_state), 63);
        decide("R6", 63, 1'b0, 300, 299);
        check("R6", "63 holds on LPS", int'(res_state), 63);
        decide("R6", 62, 1'b1, 500, 499);
    endtask

    task automatic t_backpressure();
        int lw_a = ref_lps(12, 320);
        int lw_b = ref_lps(3, 300);
        @(negedge clk);
        res_ready  = 1'b0;
        req_valid  = 1'b1;
        req_init   = 1'b0;
        req_state  = 6'd12;
        req_mps    = 1'b1;
        req_range  = 9'd320;
        req_offset = 9'd5;
        @(negedge clk);
        check("R9", "valid after accept", int'(res_valid), 1);
        req_state  = 6'd3;
        req_mps    = 1'b0;
        req_range  = 9'd300;
        req_offset = 9'd299;
        check("R9", "ready low while stalled", int'(req_ready), 0);
        @(negedge clk);
        @(negedge clk);
        check("R9", "held range", int'(res_range), 320 - lw_a);
        check("R9", "held state", int'(res_state), 13);
        res_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "second valid", int'(res_valid), 1);
        check("R9", "second range", int'(res_range), lw_b);
        check("R9", "second offset", int'(res_offset), 299 - (300 - lw_b));
        @(negedge clk);
        check("R9", "drained", int'(res_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_init();
        t_table_anchor();
        t_quarters();
        t_mps_lps();
        t_state_zero();
        t_equality();
        t_saturation();
        t_backpressure();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule